// File: doc/BRIEF.md
# Pointer Masking Address Transform Unit

This block removes software tag bits from the upper end of a 64-bit effective address before the address reaches translation. A 2-bit masking mode picks how many upper bits are masked: none, 7 or 16. The fill depends on translation. When paging is active the masked bits become copies of the highest bit that is kept, so the result is a canonical sign-extended virtual address. When translation is bare the masked bits become zero.

Three mode fields are held here, one per configuration register: machine security config, machine environment config and supervisor environment config. The current privilege level picks which field is in force. Software writes to the fields pass through a legalizer. The reserved encoding is refused, writes are refused when the feature strap is low or the datapath is 32 bits wide, and the supervisor field does not exist when supervisor mode is not built. The address path is combinational. Mode fields update on the clock edge of an accepted write.

Top module: `pm_addr_mask`

## Requirements
- R1: After reset all three mode fields are 00, so `addr_o` equals `addr_i` and every readback is zero.
- R2: Each mode field sits at bits [MODE_LSB+1:MODE_LSB] (33:32 by default) of its register. Encoding 00 means no masking, 10 masks 7 bits and 11 masks 16 bits.
- R3: A write whose mode field holds the reserved code 01 leaves the stored field unchanged.
- R4: Mode writes are ignored when `feat_en_i` is low or XLEN is 32. All register bits outside the mode field always read as zero.
- R5: When `paging_i` is nonzero (paged), the masked bits are filled with copies of bit XLEN-PMLEN-1, which is bit 56 for a 7-bit mask and bit 47 for a 16-bit mask.
- R6: When `paging_i` is 00 (bare), the masked bits are forced to zero.
- R7: Bits XLEN-PMLEN-1 down to 0 always pass through unchanged, and with mode 00 the whole address passes through.
- R8: With `priv_i` = 11 (machine), or the unused code 10, the machine security field is in force. With `priv_i` = 01 (supervisor), the machine environment field is in force.
- R9: With `priv_i` = 00 (user), the supervisor environment field is in force when HAS_SMODE = 1, and the machine environment field when HAS_SMODE = 0. When HAS_SMODE = 0 the supervisor field ignores writes and reads as zero.
- R10: `csr_sel_i` picks the register for both write and readback: 00 machine security, 01 machine environment, 10 supervisor environment. Code 11 is none: writes are ignored and the readback is zero. Readback is combinational.
- R11: An accepted write changes the transform from the first cycle after its clock edge. The address transform has no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| feat_en_i | input | 1 | Feature-enable strap for pointer masking |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register select for write and readback |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Readback of the selected register |
| priv_i | input | 2 | Current privilege level |
| paging_i | input | 2 | Translation mode, 00 bare, otherwise paged |
| addr_i | input | XLEN | Effective address in |
| addr_o | output | XLEN | Masked address out |

## Verification
On every cycle the assertions check that writes with the reserved code or with the strap low change no field, that the kept low bits always pass through, and that bare mode zero-fills while paged mode sign-fills. They also check that mode 00 is a pass-through and that machine privilege uses the machine security field. The bench's scenarios are needed to show the full privilege-to-field mapping, including the user fallback when supervisor mode is absent, along with readback values, select code 11, and the exact sign source bit against a reference function. They do this across every privilege, paging and encoding combination on a build with supervisor mode and a build without it.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_RSVD  = 2'b01;
  localparam logic [1:0] MODE_LEN_A = 2'b10;
  localparam logic [1:0] MODE_LEN_B = 2'b11;

  localparam int unsigned PMLEN_A = 7;
  localparam int unsigned PMLEN_B = 16;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] SEL_MSEC = 2'b00;
  localparam logic [1:0] SEL_MENV = 2'b01;
  localparam logic [1:0] SEL_SENV = 2'b10;

  localparam int unsigned NUM_FIELDS = 3;
endpackage

// File: rtl/pm_mode_regs.sv
module pm_mode_regs
  import pm_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned MODE_LSB  = 32,
  parameter bit          HAS_SMODE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            feat_en_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_sel_i,
  input  logic [1:0]      wfield_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [1:0]      msec_o,
  output logic [1:0]      menv_o,
  output logic [1:0]      senv_o
);
  localparam bit WIDE_OK = (XLEN != 32);

  logic [1:0] field_q [NUM_FIELDS];
  logic       wr_ok;

  assign wr_ok = csr_we_i && feat_en_i && WIDE_OK && (wfield_i != MODE_RSVD);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == int'(SEL_SENV) && !HAS_SMODE) begin : g_absent
      assign field_q[g] = MODE_OFF;
    end else begin : g_present
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          field_q[g] <= MODE_OFF;
        end else if (wr_ok && csr_sel_i == 2'(g)) begin
          field_q[g] <= wfield_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (csr_sel_i != 2'b11) begin
      rdata_o[MODE_LSB +: 2] = field_q[csr_sel_i];
    end
  end

  assign msec_o = field_q[SEL_MSEC];
  assign menv_o = field_q[SEL_MENV];
  assign senv_o = field_q[SEL_SENV];
endmodule

// File: rtl/pm_mode_select.sv
module pm_mode_select
  import pm_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic [1:0] priv_i,
  input  logic [1:0] msec_i,
  input  logic [1:0] menv_i,
  input  logic [1:0] senv_i,
  output logic [1:0] mode_o
);
  always_comb begin
    unique case (priv_i)
      PRIV_U:  mode_o = HAS_SMODE ? senv_i : menv_i;
      PRIV_S:  mode_o = menv_i;
      default: mode_o = msec_i;
    endcase
  end
endmodule

// File: rtl/pm_addr_xform.sv
module pm_addr_xform
  import pm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [1:0]      mode_i,
  input  logic            paged_i,
  input  logic [XLEN-1:0] addr_i,
  output logic [XLEN-1:0] addr_o
);
  localparam int unsigned SRC_A = XLEN - PMLEN_A - 1;
  localparam int unsigned SRC_B = XLEN - PMLEN_B - 1;

  logic fill_a, fill_b;

  // Sign fill only when paged; bare zero-fills.
  assign fill_a = paged_i & addr_i[SRC_A];
  assign fill_b = paged_i & addr_i[SRC_B];

  always_comb begin
    addr_o = addr_i;
    unique case (mode_i)
      MODE_LEN_A: addr_o[XLEN-1 -: PMLEN_A] = {PMLEN_A{fill_a}};
      MODE_LEN_B: addr_o[XLEN-1 -: PMLEN_B] = {PMLEN_B{fill_b}};
      default:    addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/pm_addr_mask.sv
module pm_addr_mask
  import pm_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned MODE_LSB  = 32,
  parameter bit          HAS_SMODE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            feat_en_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic [1:0]      priv_i,
  input  logic [1:0]      paging_i,
  input  logic [XLEN-1:0] addr_i,
  output logic [XLEN-1:0] addr_o
);
  logic [1:0] msec_q, menv_q, senv_q, eff_mode;

  pm_mode_regs #(
    .XLEN(XLEN), .MODE_LSB(MODE_LSB), .HAS_SMODE(HAS_SMODE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .feat_en_i(feat_en_i),
    .csr_we_i (csr_we_i),
    .csr_sel_i(csr_sel_i),
    .wfield_i (csr_wdata_i[MODE_LSB +: 2]),
    .rdata_o  (csr_rdata_o),
    .msec_o   (msec_q),
    .menv_o   (menv_q),
    .senv_o   (senv_q)
  );

  pm_mode_select #(.HAS_SMODE(HAS_SMODE)) u_sel (
    .priv_i(priv_i),
    .msec_i(msec_q),
    .menv_i(menv_q),
    .senv_i(senv_q),
    .mode_o(eff_mode)
  );

  pm_addr_xform #(.XLEN(XLEN)) u_xform (
    .mode_i (eff_mode),
    .paged_i(paging_i != 2'b00),
    .addr_i (addr_i),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/pm_addr_mask_chk.sv
module pm_addr_mask_chk
  import pm_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned MODE_LSB = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            feat_en_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [1:0]      priv_i,
  input logic [1:0]      paging_i,
  input logic [XLEN-1:0] addr_i,
  input logic [XLEN-1:0] addr_o,
  input logic [1:0]      msec_q,
  input logic [1:0]      menv_q,
  input logic [1:0]      senv_q
);
  logic [5:0] all_q;
  assign all_q = {msec_q, menv_q, senv_q};

  p_rsvd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[MODE_LSB +: 2] == MODE_RSVD) |=> $stable(all_q));

  p_strap_off_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feat_en_i) |=> $stable(all_q));

  p_low_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[XLEN-PMLEN_B-1:0] == addr_i[XLEN-PMLEN_B-1:0]);

  p_bare_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paging_i == 2'b00) |-> (addr_o[XLEN-1 -: PMLEN_A] == '0 || addr_o == addr_i));

  p_paged_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paging_i != 2'b00 && priv_i == PRIV_M && msec_q == MODE_LEN_A) |->
      addr_o[XLEN-1 -: PMLEN_A+1] == {(PMLEN_A+1){addr_i[XLEN-PMLEN_A-1]}});

  p_machine_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_M && msec_q == MODE_OFF) |-> addr_o == addr_i);
endmodule

bind pm_addr_mask pm_addr_mask_chk #(.XLEN(XLEN), .MODE_LSB(MODE_LSB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .feat_en_i  (feat_en_i),
  .csr_we_i   (csr_we_i),
  .csr_wdata_i(csr_wdata_i),
  .priv_i     (priv_i),
  .paging_i   (paging_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .msec_q     (msec_q),
  .menv_q     (menv_q),
  .senv_q     (senv_q)
);

// File: tb/pm_addr_mask_tb_top.sv
`timescale 1ns/1ps
module pm_addr_mask_tb_top;
  localparam int XL = 64;
  localparam int ML = 32;

  typedef struct {
    logic [XL-1:0] exp_a;
    logic [XL-1:0] exp_b;
    logic [XL-1:0] exp_rd_a;
    logic [XL-1:0] exp_rd_b;
    string         tag;
  } item_t;

  logic          clk = 0, rst_n = 0, feat_en = 1, we = 0;
  logic [1:0]    sel = 0, priv = 2'b11, paging = 0;
  logic [XL-1:0] wdata = '0, addr = '0;
  logic [XL-1:0] rd_a, rd_b, ao_a, ao_b;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];
  event chk_ev;

  logic [1:0] sh_a [3];
  logic [1:0] sh_b [3];

  always #2.5 clk = ~clk;

  pm_addr_mask #(.XLEN(XL), .MODE_LSB(ML), .HAS_SMODE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .feat_en_i(feat_en), .csr_we_i(we),
    .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rd_a),
    .priv_i(priv), .paging_i(paging), .addr_i(addr), .addr_o(ao_a));

  pm_addr_mask #(.XLEN(XL), .MODE_LSB(ML), .HAS_SMODE(1'b0)) dut_nos_i (
    .clk_i(clk), .rst_ni(rst_n), .feat_en_i(feat_en), .csr_we_i(we),
    .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rd_b),
    .priv_i(priv), .paging_i(paging), .addr_i(addr), .addr_o(ao_b));

  function automatic logic [XL-1:0] ref_x(logic [1:0] m, logic pg, logic [XL-1:0] a);
    logic [XL-1:0] r = a;
    int n = (m == 2'b10) ? 7 : (m == 2'b11) ? 16 : 0;
    for (int i = XL - n; i < XL; i++) r[i] = pg ? a[XL-n-1] : 1'b0;
    return r;
  endfunction

  function automatic logic [1:0] ref_mode(logic [1:0] p, bit has_s, logic [1:0] s [3]);
    if (p == 2'b00) return has_s ? s[2] : s[1];
    if (p == 2'b01) return s[1];
    return s[0];
  endfunction

  function automatic logic [XL-1:0] ref_rd(logic [1:0] sl, logic [1:0] s [3]);
    logic [XL-1:0] r = '0;
    if (sl != 2'b11) r[ML +: 2] = s[sl];
    return r;
  endfunction

  task automatic csr_write(logic [1:0] s, logic [XL-1:0] d);
    @(negedge clk);
    we = 1; sel = s; wdata = d;
    @(posedge clk); #1;
    we = 0;
    if (feat_en && s != 2'b11 && d[ML +: 2] != 2'b01) begin
      sh_a[s] = d[ML +: 2];
      if (s != 2'b10) sh_b[s] = d[ML +: 2];
    end
  endtask

  task automatic apply(logic [1:0] p, logic [1:0] pg, logic [XL-1:0] a,
                       logic [1:0] s, string tag);
    item_t it;
    @(negedge clk);
    priv = p; paging = pg; addr = a; sel = s;
    it.exp_a    = ref_x(ref_mode(p, 1'b1, sh_a), pg != 0, a);
    it.exp_b    = ref_x(ref_mode(p, 1'b0, sh_b), pg != 0, a);
    it.exp_rd_a = ref_rd(s, sh_a);
    it.exp_rd_b = ref_rd(s, sh_b);
    it.tag = tag;
    q.push_back(it);
    #1 -> chk_ev;
    #1;
  endtask

  task automatic cmp(string tag, string what, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(chk_ev);
      it = q.pop_front();
      cmp(it.tag, "addr_s", ao_a, it.exp_a);
      cmp(it.tag, "addr_nos", ao_b, it.exp_b);
      cmp(it.tag, "rd_s", rd_a, it.exp_rd_a);
      cmp(it.tag, "rd_nos", rd_b, it.exp_rd_b);
    end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [XL-1:0] fld(logic [1:0] m);
    logic [XL-1:0] d = {XL{1'b1}};   // other bits set: must read back as zero (R4)
    d[ML +: 2] = m;
    return d;
  endfunction

  localparam logic [XL-1:0] ADDRS [6] = '{
    64'hA5A5_0123_4567_89AB, 64'h0100_0000_0000_0000, 64'h0000_8000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h7E80_7FFF_1234_5678};
  localparam logic [1:0] MODES [3] = '{2'b00, 2'b10, 2'b11};

  initial begin : driver
    for (int i = 0; i < 3; i++) begin sh_a[i] = 0; sh_b[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, every select readback and pass-through
    for (int s = 0; s < 4; s++) apply(2'b11, 2'b01, ADDRS[0], 2'(s), "R1");
    apply(2'b00, 2'b00, ADDRS[3], 2'b10, "R1");

    // R2 R5 R6 R7 R8 R9: every field encoding, privilege, paging and address
    foreach (MODES[m]) begin
      for (int s = 0; s < 3; s++) csr_write(2'(s), fld(MODES[m]));
      for (int p = 0; p < 4; p++)
        for (int pg = 0; pg < 3; pg++)
          foreach (ADDRS[k]) apply(2'(p), 2'(pg), ADDRS[k], 2'(p % 3), "R2_R5_R6_R7");
    end

    // R8 R9: distinct field per register exposes the source selection
    csr_write(2'b00, fld(2'b10));
    csr_write(2'b01, fld(2'b11));
    csr_write(2'b10, fld(2'b00));
    for (int p = 0; p < 4; p++)
      foreach (ADDRS[k]) apply(2'(p), 2'b01, ADDRS[k], 2'b10, "R8_R9");

    // R3: reserved code ignored
    csr_write(2'b01, fld(2'b01));
    apply(2'b01, 2'b10, ADDRS[1], 2'b01, "R3");
    csr_write(2'b00, fld(2'b01));
    apply(2'b11, 2'b00, ADDRS[3], 2'b00, "R3");

    // R4: strap low blocks writes
    feat_en = 0;
    csr_write(2'b00, fld(2'b00));
    csr_write(2'b10, fld(2'b11));
    feat_en = 1;
    apply(2'b11, 2'b01, ADDRS[2], 2'b00, "R4");
    apply(2'b00, 2'b01, ADDRS[2], 2'b10, "R4");

    // R10: select 11 writes nothing and reads zero
    csr_write(2'b11, fld(2'b00));
    for (int s = 0; s < 4; s++) apply(2'b11, 2'b10, ADDRS[1], 2'(s), "R10");

    // R11: effect visible in the cycle after the write edge, not before
    @(negedge clk);
    priv = 2'b01; paging = 2'b01; addr = ADDRS[3]; sel = 2'b01;
    wdata = fld(2'b00); we = 1;
    #1 cmp("R11", "before_edge", ao_a, ref_x(2'b11, 1'b1, ADDRS[3]));
    @(posedge clk); #1 we = 0;
    sh_a[1] = 2'b00; sh_b[1] = 2'b00;
    cmp("R11", "after_edge", ao_a, ADDRS[3]);

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule